// File: doc/BRIEF.md
# USB Host Bus-State Controller

This block holds the three command bits that software uses to steer a USB host port's bus: a bus-reset request, a bus-resume request and a frame-generation enable. It turns them into line-state requests for a downstream transceiver. Those requests are to drive reset signalling, to drive resume signalling, to pulse a start-of-frame trigger once per frame at full speed, or to pulse a keep-alive marker once per frame at low speed. Cycle counters time every event from a clock frequency given in kHz. The frame is 1 ms long. Reset and resume last a whole number of milliseconds, 50 ms and 20 ms by default.

The command bits are coupled to one another and clear themselves. The block drops a reset or resume bit when its interval expires and marks the end with a one-cycle done pulse. A reset request cancels any resume and forces frame generation on. An upstream resume seen on the bus also forces frame generation on. Writing zero to the reset bit in the middle of a reset cuts it short, and so does a device-disconnect indication. Either abort ends the reset without a done pulse. Frame markers stop while reset or resume is active. The frame counter starts again from zero when the event ends.

Top module: `usbh_bus_ctrl`

## Requirements
- R1: After synchronous reset, the read-back word is zero and every line-state and pulse output is low.
- R2: With frame enable set, writing 1 to the resume bit (bit 2) drives resume signalling for exactly RESUME_MS*CLK_KHZ cycles, starting the cycle after the write. The bit then clears, and resume_done_o pulses for one cycle in the first cycle it is low.
- R3: Writing 0 to the resume bit has no effect on a running resume. Writing 1 to the resume bit while frame enable (bit 0) is clear is ignored, and so is writing 1 while a reset is active.
- R4: Writing 1 to the reset bit (bit 1) drives reset signalling for exactly RESET_MS*CLK_KHZ cycles. The bit then clears and reset_done_o pulses in the first cycle it is low. The request sets frame enable even when the written bit 0 is zero.
- R5: A reset request clears a resume in progress in the same cycle it starts, and reset and resume are never driven together.
- R6: While a reset runs, writing 0 to the reset bit, or asserting dev_disc_i, ends it the next cycle with no reset_done_o pulse.
- R7: At full speed with frame enable set and no event active, sof_o pulses once every CLK_KHZ cycles. The first pulse comes CLK_KHZ cycles after frame generation starts.
- R8: When full_speed_i is low, keepalive_o pulses with the same timing in place of sof_o.
- R9: Clearing frame enable stops all frame markers.
- R10: A pulse on rx_resume_i sets frame enable in the next cycle.
- R11: No frame marker appears while reset or resume is active. The first marker after an event comes CLK_KHZ cycles after the event bit clears.
- R12: Read-back bits 31 to 3 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | 3 | Command write value: bit0 frame enable, bit1 reset, bit2 resume |
| rd_data_o | output | 32 | Command read-back, unused bits zero |
| full_speed_i | input | 1 | 1 selects full-speed SOF triggers, 0 low-speed keep-alive |
| rx_resume_i | input | 1 | Upstream resume detected |
| dev_disc_i | input | 1 | Device disconnect detected |
| drive_reset_o | output | 1 | Request transceiver to drive bus reset |
| drive_resume_o | output | 1 | Request transceiver to drive resume signalling |
| sof_o | output | 1 | One-cycle start-of-frame trigger |
| keepalive_o | output | 1 | One-cycle low-speed keep-alive marker |
| reset_done_o | output | 1 | One-cycle pulse when a reset completes |
| resume_done_o | output | 1 | One-cycle pulse when a resume completes |

## Verification
The frame path is tested in three states. At full speed it shows SOF pacing. After a mid-run switch of the speed input it shows that keep-alive replaces SOF with no change in period. With frame enable cleared it shows that the markers are gone. Resume is tried both with frame enable clear and with it set. That separates the gating rule from the timing. A zero written during a resume shows that such writes have no effect. Reset is tried four ways, each of which has a distinct result: a clean run to completion, a reset that overrides a running resume, an abort by software write, and an abort by disconnect. Marker timestamps after each event show that the frame counter restarts and was not left running.

// File: rtl/usbh_bus_pkg.sv
package usbh_bus_pkg;
  localparam int CMD_W   = 3;
  localparam int BIT_FEN = 0;
  localparam int BIT_RST = 1;
  localparam int BIT_RSM = 2;
  localparam int RD_W    = 32;

  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,
    EV_RESET  = 2'd1,
    EV_RESUME = 2'd2
  } ev_mode_t;
endpackage

// File: rtl/usbh_cmd_reg.sv
module usbh_cmd_reg
  import usbh_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             rx_resume,
  input  logic             dev_disc,
  input  logic             rst_expire,
  input  logic             rsm_expire,
  output logic             fen_q,
  output logic             rst_q,
  output logic             rsm_q
);
  logic fen_d, rst_d, rsm_d;
  logic rst_req, rst_abort;

  always_comb begin
    rst_req   = wr_en && wr_data[BIT_RST];
    rst_abort = rst_q && (dev_disc || (wr_en && !wr_data[BIT_RST]));
    fen_d = fen_q;
    rst_d = rst_q;
    rsm_d = rsm_q;
    if (wr_en) fen_d = wr_data[BIT_FEN];
    // resume accepted only with frames running and no reset pending
    if (wr_en && wr_data[BIT_RSM] && fen_q && !rst_q && !rst_req) rsm_d = 1'b1;
    if (rsm_expire) rsm_d = 1'b0;
    if (rst_req) begin
      rsm_d = 1'b0;
      fen_d = 1'b1;
      if (!rst_q) rst_d = 1'b1;
    end
    if (rst_abort || rst_expire) rst_d = 1'b0;
    if (rx_resume) fen_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fen_q <= 1'b0;
      rst_q <= 1'b0;
      rsm_q <= 1'b0;
    end else begin
      fen_q <= fen_d;
      rst_q <= rst_d;
      rsm_q <= rsm_d;
    end
  end

  p_resume_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[BIT_RSM] && !fen_q && !rsm_q) |=> !rsm_q);

  p_reset_start_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[BIT_RST] && !rst_q) |=> (rst_q && fen_q && !rsm_q));

  p_disc_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (rst_q && dev_disc) |=> !rst_q);

  p_upstream_fen_r10: assert property (@(posedge clk) disable iff (rst)
    rx_resume |=> fen_q);
endmodule

// File: rtl/usbh_event_timer.sv
module usbh_event_timer
  import usbh_bus_pkg::*;
#(
  parameter int RST_CYC = 2400000,
  parameter int RSM_CYC = 960000
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_act,
  input  logic rsm_act,
  output logic rst_expire,
  output logic rsm_expire
);
  localparam int MAX_CYC = (RST_CYC > RSM_CYC) ? RST_CYC : RSM_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] RSM_LAST = CW'(RSM_CYC - 1);

  ev_mode_t      mode_cur, mode_q;
  logic [CW-1:0] cnt, cnt_eff;

  always_comb begin
    if (rst_act)      mode_cur = EV_RESET;
    else if (rsm_act) mode_cur = EV_RESUME;
    else              mode_cur = EV_IDLE;
    cnt_eff    = (mode_cur != mode_q) ? '0 : cnt;
    rst_expire = (mode_cur == EV_RESET)  && (cnt_eff == RST_LAST);
    rsm_expire = (mode_cur == EV_RESUME) && (cnt_eff == RSM_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= EV_IDLE;
      cnt    <= '0;
    end else begin
      mode_q <= mode_cur;
      cnt    <= (mode_cur == EV_IDLE) ? '0 : cnt_eff + 1'b1;
    end
  end

  p_rst_len_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == EV_RESET) |-> (cnt <= CW'(RST_CYC)));

  p_rsm_len_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == EV_RESUME) |-> (cnt <= CW'(RSM_CYC)));
endmodule

// File: rtl/usbh_frame_timer.sv
module usbh_frame_timer #(
  parameter int FRAME_CYC = 48000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic full_speed,
  output logic sof,
  output logic keepalive
);
  localparam int FW = $clog2(FRAME_CYC + 1);
  localparam logic [FW-1:0] LAST = FW'(FRAME_CYC - 1);

  logic [FW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sof       <= 1'b0;
      keepalive <= 1'b0;
    end else begin
      if (!run || tick) cnt <= '0;
      else              cnt <= cnt + 1'b1;
      sof       <= tick && full_speed;
      keepalive <= tick && !full_speed;
    end
  end

  p_one_marker_r8: assert property (@(posedge clk) disable iff (rst)
    !(sof && keepalive));

  p_marker_needs_run_r11: assert property (@(posedge clk) disable iff (rst)
    (sof || keepalive) |-> $past(run));
endmodule

// File: rtl/usbh_bus_ctrl.sv
module usbh_bus_ctrl
  import usbh_bus_pkg::*;
#(
  parameter int CLK_KHZ   = 48000,
  parameter int RESET_MS  = 50,
  parameter int RESUME_MS = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [CMD_W-1:0] wr_data_i,
  output logic [RD_W-1:0]  rd_data_o,
  input  logic             full_speed_i,
  input  logic             rx_resume_i,
  input  logic             dev_disc_i,
  output logic             drive_reset_o,
  output logic             drive_resume_o,
  output logic             sof_o,
  output logic             keepalive_o,
  output logic             reset_done_o,
  output logic             resume_done_o
);
  localparam int FRAME_CYC = CLK_KHZ;
  localparam int RST_CYC   = CLK_KHZ * RESET_MS;
  localparam int RSM_CYC   = CLK_KHZ * RESUME_MS;

  logic fen_q, rst_q, rsm_q;
  logic rst_expire, rsm_expire;
  logic frame_run;

  usbh_cmd_reg u_cmd (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en_i),
    .wr_data    (wr_data_i),
    .rx_resume  (rx_resume_i),
    .dev_disc   (dev_disc_i),
    .rst_expire (rst_expire),
    .rsm_expire (rsm_expire),
    .fen_q      (fen_q),
    .rst_q      (rst_q),
    .rsm_q      (rsm_q)
  );

  usbh_event_timer #(
    .RST_CYC (RST_CYC),
    .RSM_CYC (RSM_CYC)
  ) u_evt (
    .clk        (clk),
    .rst        (rst),
    .rst_act    (rst_q),
    .rsm_act    (rsm_q),
    .rst_expire (rst_expire),
    .rsm_expire (rsm_expire)
  );

  assign frame_run = fen_q && !rst_q && !rsm_q;

  usbh_frame_timer #(
    .FRAME_CYC (FRAME_CYC)
  ) u_frm (
    .clk        (clk),
    .rst        (rst),
    .run        (frame_run),
    .full_speed (full_speed_i),
    .sof        (sof_o),
    .keepalive  (keepalive_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_done_o  <= 1'b0;
      resume_done_o <= 1'b0;
    end else begin
      reset_done_o  <= rst_expire;
      resume_done_o <= rsm_expire;
    end
  end

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[BIT_FEN] = fen_q;
    rd_data_o[BIT_RST] = rst_q;
    rd_data_o[BIT_RSM] = rsm_q;
  end

  assign drive_reset_o  = rst_q;
  assign drive_resume_o = rsm_q;

  p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(drive_reset_o && drive_resume_o));

  p_rst_done_r4: assert property (@(posedge clk) disable iff (rst)
    reset_done_o |-> ($past(drive_reset_o) && !drive_reset_o));

  p_rsm_done_r2: assert property (@(posedge clk) disable iff (rst)
    resume_done_o |-> ($past(drive_resume_o) && !drive_resume_o));

  p_no_marker_in_event_r11: assert property (@(posedge clk) disable iff (rst)
    (drive_reset_o || drive_resume_o) |=> !(sof_o || keepalive_o));
endmodule

// File: tb/sim_usbh_bus_ctrl.sv
`timescale 1ns/1ps
module sim_usbh_bus_ctrl;
  localparam int KHZ = 20;
  localparam int F   = KHZ;
  localparam int RL  = KHZ * 4;
  localparam int SL  = KHZ * 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_data = '0;
  logic [31:0] rd_data;
  logic        full_speed = 1'b1;
  logic        rx_resume = 1'b0;
  logic        dev_disc = 1'b0;
  logic        drv_rst, drv_rsm, sof, ka, rst_done, rsm_done;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit mon_on = 1'b0;

  typedef struct { int kind; int t; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usbh_bus_ctrl #(.CLK_KHZ(KHZ), .RESET_MS(4), .RESUME_MS(2)) u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .full_speed_i(full_speed), .rx_resume_i(rx_resume),
    .dev_disc_i(dev_disc), .drive_reset_o(drv_rst), .drive_resume_o(drv_rsm),
    .sof_o(sof), .keepalive_o(ka), .reset_done_o(rst_done),
    .resume_done_o(rsm_done)
  );

  function automatic string kname(int k);
    case (k)
      0: return "R7 sof";
      1: return "R8 keepalive";
      2: return "R4 reset_done";
      default: return "R2 resume_done";
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic expect_ev(int kind, int t);
    exp_t e;
    e.kind = kind;
    e.t = t;
    q.push_back(e);
  endtask

  task automatic observe(int kind);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R9/R11 unexpected %s: got cycle %0d expected none", kname(kind), cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.t != cyc) begin
        errors++;
        $display("FAIL %s: got %s at %0d expected %s at %0d",
                 kname(e.kind), kname(kind), cyc, kname(e.kind), e.t);
      end
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (sof)      observe(0);
      if (ka)       observe(1);
      if (rst_done) observe(2);
      if (rsm_done) observe(3);
    end
  end

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wr_at(int t, logic [2:0] d);
    wait_to(t - 1);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rxr_at(int t);
    wait_to(t - 1);
    rx_resume = 1'b1;
    @(negedge clk);
    rx_resume = 1'b0;
  endtask

  task automatic disc_at(int t);
    wait_to(t - 1);
    dev_disc = 1'b1;
    @(negedge clk);
    dev_disc = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int w, w2, e, r, x, y;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    mon_on = 1'b1;
    // R1 reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 outputs", int'({drv_rst, drv_rsm, sof, ka, rst_done, rsm_done}), 0);

    // R3 resume write with frame enable clear is ignored
    w = cyc + 2;
    wr_at(w, 3'b100);
    chk("R3 gated resume rd", int'(rd_data), 0);
    chk("R3 gated resume line", int'(drv_rsm), 0);

    // R7 full-speed SOF pacing
    w = cyc + 5;
    expect_ev(0, w + F);
    expect_ev(0, w + 2*F);
    wr_at(w, 3'b001);
    chk("R7 fen set", int'(rd_data), 1);

    // R2 resume timing, R11 suppression
    w2 = w + 45;
    expect_ev(3, w2 + SL);
    wr_at(w2, 3'b101);
    chk("R2 resume starts", int'(drv_rsm), 1);
    wr_at(w2 + 10, 3'b001);
    chk("R3 zero write keeps resume", int'(rd_data), 5);
    wait_to(w2 + SL - 1);
    chk("R2 resume last cycle", int'(drv_rsm), 1);
    e = w2 + SL;
    expect_ev(0, e + F);
    expect_ev(0, e + 2*F);
    wait_to(e);
    chk("R2 resume cleared", int'(drv_rsm), 0);

    // R8 low-speed keep-alive
    expect_ev(1, e + 3*F);
    expect_ev(1, e + 4*F);
    wait_to(e + 45);
    full_speed = 1'b0;

    // R9 clearing frame enable stops markers
    wr_at(e + 85, 3'b000);
    chk("R9 fen cleared", int'(rd_data), 0);

    // R10 upstream resume sets frame enable
    expect_ev(1, e + 100 + F);
    rxr_at(e + 100);
    chk("R10 fen by upstream resume", int'(rd_data), 1);
    chk("R12 unused bits zero", int'(rd_data[31:3]), 0);

    // R4 reset with fen bit written zero
    r = e + 125;
    expect_ev(2, r + RL);
    wr_at(r, 3'b010);
    chk("R4 reset drives, fen forced", int'(rd_data), 3);
    wr_at(r + 10, 3'b111);
    chk("R3 resume ignored in reset", int'(rd_data), 3);
    chk("R5 no resume line in reset", int'(drv_rsm), 0);
    wait_to(r + RL - 1);
    chk("R4 reset last cycle", int'(drv_rst), 1);
    expect_ev(1, r + RL + F);
    wait_to(r + RL);
    chk("R4 reset cleared", int'(rd_data), 1);

    // R5 reset overrides running resume, R6 write abort
    x = r + 105;
    wr_at(x, 3'b101);
    chk("R2 second resume starts", int'(drv_rsm), 1);
    wr_at(x + 5, 3'b011);
    chk("R5 reset clears resume", int'(rd_data), 3);
    chk("R5 resume line dropped", int'(drv_rsm), 0);
    expect_ev(1, x + 30 + F);
    wr_at(x + 30, 3'b001);
    chk("R6 write abort", int'(rd_data), 1);

    // R6 disconnect abort
    y = x + 55;
    wr_at(y, 3'b011);
    chk("R6 reset restarted", int'(drv_rst), 1);
    expect_ev(1, y + 10 + F);
    disc_at(y + 10);
    chk("R6 disconnect abort", int'(rd_data), 1);
    wr_at(y + 35, 3'b000);
    wait_to(y + 90);
    chk("R11 all expected events seen", q.size(), 0);
    finish_run();
  end
endmodule